// File: doc/BRIEF.md
# Channel-Tuned Synthesizer Divider Chain

This block is the digital half of a frequency synthesizer whose channel is chosen from a small table. The crystal reference is divided by a fixed ratio down to the comparison rate. The oscillator feedback goes through a fixed prescaler and then through a programmable divider, which brings it down to the same rate. A phase-frequency comparator then drives up and down pump requests toward an external loop filter. A lock indicator reports when the two divided edges have stayed close together for a run of comparisons.

Both the reference and the oscillator feedback reach the block as single-cycle tick strobes, each synchronous to one fast core clock. Every divider counts those ticks, so the whole chain runs in one clock domain. To choose a channel, drive an index and pulse the load strobe. The ratio for that channel is the base ratio plus the index times a fixed step, clamped to the allowed bounds. The new ratio waits in a holding register until the programmable divider reaches its terminal count. The division cycle already under way therefore always completes at its full old length.

Top module: `chan_synth_divider`

## Requirements
- R1: `ref_pulse` is high, in the same cycle, on every REF_DIV-th `ref_tick` counted from reset, and is low otherwise.
- R2: `fb_pulse` is high, in the same cycle, on the `fb_tick` that completes PRE_DIV times N feedback ticks, where N is the active programmable ratio. It is low otherwise.
- R3: Loading index c selects the ratio RATIO_BASE + RATIO_STEP*c, clamped to RATIO_MIN..RATIO_MAX. The divide cycle in progress at the load finishes with the old ratio, and the new ratio governs the cycles after it.
- R4: `range_err` becomes 1 in the cycle after a load whose unclamped ratio lies outside RATIO_MIN..RATIO_MAX, becomes 0 in the cycle after an in-range load, and otherwise keeps its value.
- R5: Under reset `pump_up`, `pump_dn`, `locked` and `range_err` are 0. After reset the active ratio is the clamped ratio of index 0.
- R6: `pump_up` rises in the cycle after `ref_pulse` and `pump_dn` rises in the cycle after `fb_pulse`. Each stays high until the cycle after the one in which both are high, when both return to 0 together. An edge arriving in that both-high cycle is dropped.
- R7: A comparison ends in each both-high cycle. It is good when fewer than SLIP_LIMIT cycles had exactly one of the two pumps high since the previous comparison. `locked` is 1 once LOCK_RUNS good comparisons have occurred in a row. A bad comparison clears the run, and so does any load, with effect in the next cycle.
- R8: If two loads occur before the divider's terminal count, only the later one takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| fb_tick | input | 1 | One-cycle strobe per oscillator feedback period |
| chan_sel | input | CHAN_BITS | Channel index sampled on load |
| chan_load | input | 1 | Load strobe for the channel index |
| ref_pulse | output | 1 | Divided reference event |
| fb_pulse | output | 1 | Divided feedback event |
| pump_up | output | 1 | Comparator up request |
| pump_dn | output | 1 | Comparator down request |
| locked | output | 1 | Lock indicator |
| range_err | output | 1 | Last loaded channel ratio was clamped |

## Verification
The bench uses a reference divide of 6 and a prescaler of 2. The ratio bounds are 3..20, with eight channels at base 1 and step 3. Channel 0 (raw 1) and channel 7 (raw 22) therefore both hit the clamp, and every divide cycle lasts only tens of core cycles. Lock detection keeps its full run of 16 with a slip limit of 3, so the bench can acquire lock with a tick phase offset of one cycle and then break it with a channel change. It can also observe old-ratio completion, back-to-back loads and both clamp directions, all within a couple of thousand cycles.

// File: rtl/chan_synth_pkg.sv
package chan_synth_pkg;

  // Bound a raw channel ratio to the legal programmable range.
  function automatic int clamp_ratio(int raw, int lo, int hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  function automatic bit ratio_outside(int raw, int lo, int hi);
    return (raw < lo) || (raw > hi);
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 1536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_out
);
  localparam int W = $clog2(DIV + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap     = (cnt_q == W'(DIV - 1));
  assign tick_out = tick_in & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_in) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_in) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/chan_ratio_table.sv
module chan_ratio_table
  import chan_synth_pkg::*;
#(
  parameter int CHAN_BITS  = 4,
  parameter int RATIO_MIN  = 256,
  parameter int RATIO_MAX  = 8191,
  parameter int RATIO_BASE = 5360,
  parameter int RATIO_STEP = 2,
  parameter int RW         = 13
) (
  input  logic [CHAN_BITS-1:0] chan_sel,
  output logic [RW-1:0]        ratio,
  output logic                 outside
);
  localparam int CHANS = 1 << CHAN_BITS;

  logic [RW-1:0]    ratio_rom [CHANS];
  logic [CHANS-1:0] outside_vec;

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    localparam int RAW = RATIO_BASE + RATIO_STEP * c;
    assign ratio_rom[c]   = RW'(clamp_ratio(RAW, RATIO_MIN, RATIO_MAX));
    assign outside_vec[c] = ratio_outside(RAW, RATIO_MIN, RATIO_MAX);
  end

  assign ratio   = ratio_rom[chan_sel];
  assign outside = outside_vec[chan_sel];
endmodule

// File: rtl/prog_divider.sv
module prog_divider #(
  parameter int RW         = 13,
  parameter int BOOT_RATIO = 5360
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          load,
  input  logic [RW-1:0] load_ratio,
  output logic          tick_out
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] ratio_q, ratio_d;
  logic [RW-1:0] pend_q, pend_d;
  logic          pend_v_q, pend_v_d;
  logic          at_end;

  assign at_end   = (cnt_q == ratio_q - 1'b1);
  assign tick_out = tick_in & at_end;

  always_comb begin
    cnt_d    = cnt_q;
    ratio_d  = ratio_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    if (tick_in) begin
      if (at_end) begin
        cnt_d = '0;
        // A waiting ratio is adopted only at the cycle boundary.
        if (pend_v_q) begin
          ratio_d  = pend_q;
          pend_v_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (load) begin
      pend_d   = load_ratio;
      pend_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ratio_q  <= RW'(BOOT_RATIO);
      pend_q   <= RW'(BOOT_RATIO);
      pend_v_q <= 1'b0;
    end else begin
      if (tick_in) cnt_q <= cnt_d;
      ratio_q  <= ratio_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
    end
  end
endmodule

// File: rtl/phase_comparator.sv
module phase_comparator (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,
  input  logic fb_ev,
  output logic up,
  output logic dn
);
  logic up_q, up_d, dn_q, dn_d, both;

  assign both = up_q & dn_q;

  always_comb begin
    if (both) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = up_q | ref_ev;
      dn_d = dn_q | fb_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up = up_q;
  assign dn = dn_q;
endmodule

// File: rtl/lock_detector.sv
module lock_detector #(
  parameter int LOCK_RUNS  = 16,
  parameter int SLIP_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic clear,
  output logic locked
);
  localparam int SW = $clog2(SLIP_LIMIT + 1);
  localparam int LW = $clog2(LOCK_RUNS + 1);

  logic [SW-1:0] slip_q, slip_d;
  logic [LW-1:0] run_q, run_d;
  logic          both, one;

  assign both = up & dn;
  assign one  = up ^ dn;

  always_comb begin
    slip_d = slip_q;
    run_d  = run_q;
    if (both) begin
      slip_d = '0;
      if (slip_q < SW'(SLIP_LIMIT))
        run_d = (run_q == LW'(LOCK_RUNS)) ? run_q : run_q + 1'b1;
      else
        run_d = '0;
    end else if (one && (slip_q < SW'(SLIP_LIMIT))) begin
      slip_d = slip_q + 1'b1;
    end
    if (clear) run_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_q <= '0;
      run_q  <= '0;
    end else begin
      slip_q <= slip_d;
      run_q  <= run_d;
    end
  end

  assign locked = (run_q == LW'(LOCK_RUNS));
endmodule

// File: rtl/chan_synth_divider.sv
module chan_synth_divider
  import chan_synth_pkg::*;
#(
  parameter int REF_DIV    = 1536,
  parameter int PRE_DIV    = 64,
  parameter int RATIO_MIN  = 256,
  parameter int RATIO_MAX  = 8191,
  parameter int CHAN_BITS  = 4,
  parameter int RATIO_BASE = 5360,
  parameter int RATIO_STEP = 2,
  parameter int LOCK_RUNS  = 16,
  parameter int SLIP_LIMIT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_tick,
  input  logic                 fb_tick,
  input  logic [CHAN_BITS-1:0] chan_sel,
  input  logic                 chan_load,
  output logic                 ref_pulse,
  output logic                 fb_pulse,
  output logic                 pump_up,
  output logic                 pump_dn,
  output logic                 locked,
  output logic                 range_err
);
  localparam int RW         = $clog2(RATIO_MAX + 1);
  localparam int BOOT_RATIO = clamp_ratio(RATIO_BASE, RATIO_MIN, RATIO_MAX);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic          pre_ev;
  logic [RW-1:0] sel_ratio;
  logic          sel_outside;
  logic          err_q, err_d;

  tick_divider #(.DIV(REF_DIV)) u_ref_div (
    .clk(clk), .rst_n(rst_core_n), .tick_in(ref_tick), .tick_out(ref_pulse)
  );

  tick_divider #(.DIV(PRE_DIV)) u_prescale (
    .clk(clk), .rst_n(rst_core_n), .tick_in(fb_tick), .tick_out(pre_ev)
  );

  chan_ratio_table #(
    .CHAN_BITS(CHAN_BITS), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX),
    .RATIO_BASE(RATIO_BASE), .RATIO_STEP(RATIO_STEP), .RW(RW)
  ) u_table (
    .chan_sel(chan_sel), .ratio(sel_ratio), .outside(sel_outside)
  );

  prog_divider #(.RW(RW), .BOOT_RATIO(BOOT_RATIO)) u_prog (
    .clk(clk), .rst_n(rst_core_n), .tick_in(pre_ev), .load(chan_load),
    .load_ratio(sel_ratio), .tick_out(fb_pulse)
  );

  phase_comparator u_pfd (
    .clk(clk), .rst_n(rst_core_n), .ref_ev(ref_pulse), .fb_ev(fb_pulse),
    .up(pump_up), .dn(pump_dn)
  );

  lock_detector #(.LOCK_RUNS(LOCK_RUNS), .SLIP_LIMIT(SLIP_LIMIT)) u_lock (
    .clk(clk), .rst_n(rst_core_n), .up(pump_up), .dn(pump_dn),
    .clear(chan_load), .locked(locked)
  );

  always_comb begin
    err_d = err_q;
    if (chan_load) err_d = sel_outside;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign range_err = err_q;
endmodule

// File: rtl/chan_synth_checker.sv
module chan_synth_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic fb_tick,
  input logic chan_load,
  input logic ref_pulse,
  input logic fb_pulse,
  input logic pump_up,
  input logic pump_dn,
  input logic locked,
  input logic range_err
);
  a_r1_ref_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> ref_tick);

  a_r2_fb_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> fb_tick);

  a_r4_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_load |=> $stable(range_err));

  a_r6_joint_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn) |=> (!pump_up && !pump_dn));

  a_r6_up_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && !(pump_up && pump_dn)) |=> pump_up);

  a_r6_dn_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && !(pump_up && pump_dn)) |=> pump_dn);

  a_r7_load_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    chan_load |=> !locked);

  a_r7_rise_after_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pump_up && pump_dn));
endmodule

bind chan_synth_divider chan_synth_checker u_check (
  .clk(clk), .rst_n(rst_core_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
  .chan_load(chan_load), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
  .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked), .range_err(range_err)
);

// File: tb/chan_synth_divider_test.sv
module chan_synth_divider_test;
  localparam int REF_DIV = 6, PRE_DIV = 2, RMIN = 3, RMAX = 20, CB = 3;
  localparam int RBASE = 1, RSTEP = 3, LRUNS = 16, SLIP = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ref_tick, fb_tick, chan_load;
  logic [CB-1:0] chan_sel;
  logic ref_pulse, fb_pulse, pump_up, pump_dn, locked, range_err;

  chan_synth_divider #(
    .REF_DIV(REF_DIV), .PRE_DIV(PRE_DIV), .RATIO_MIN(RMIN), .RATIO_MAX(RMAX),
    .CHAN_BITS(CB), .RATIO_BASE(RBASE), .RATIO_STEP(RSTEP),
    .LOCK_RUNS(LRUNS), .SLIP_LIMIT(SLIP)
  ) uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // Behavioural reference state.
  int m_rc, m_pc, m_nc, m_ratio, m_pend, m_slip, m_run;
  bit m_pv, m_up, m_dn, m_err;

  // Stimulus configuration and last driven values.
  int cyc = 0;
  bit ref_on = 0, fb_on = 0;
  int ref_per = 1, ref_start = 0, fb_per = 1, fb_start = 0;
  bit load_req = 0;
  int load_ch = 0;
  bit c_ref = 0, c_fb = 0, c_load = 0;
  int c_ch = 0;
  int last_fb = 0;
  int gaps[$];

  function automatic int raw_ratio(int ch);
    return RBASE + RSTEP * ch;
  endfunction
  function automatic int clampr(int r);
    return (r < RMIN) ? RMIN : ((r > RMAX) ? RMAX : r);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_edge();
    bit rev, pev, fev;
    rev = c_ref && (m_rc == REF_DIV - 1);
    if (c_ref) m_rc = rev ? 0 : m_rc + 1;
    pev = c_fb && (m_pc == PRE_DIV - 1);
    if (c_fb) m_pc = pev ? 0 : m_pc + 1;
    fev = pev && (m_nc == m_ratio - 1);
    if (pev) begin
      if (fev) begin
        m_nc = 0;
        if (m_pv) begin m_ratio = m_pend; m_pv = 0; end
      end else m_nc++;
    end
    if (c_load) begin
      m_pend = clampr(raw_ratio(c_ch));
      m_pv   = 1;
      m_err  = (raw_ratio(c_ch) < RMIN) || (raw_ratio(c_ch) > RMAX);
    end
    if (m_up && m_dn) begin
      m_run  = (m_slip < SLIP) ? ((m_run < LRUNS) ? m_run + 1 : LRUNS) : 0;
      m_slip = 0;
    end else if ((m_up != m_dn) && (m_slip < SLIP)) m_slip++;
    if (c_load) m_run = 0;
    if (m_up && m_dn) begin m_up = 0; m_dn = 0; end
    else begin m_up |= rev; m_dn |= fev; end
  endtask

  task automatic drive();
    c_ref  = ref_on && (cyc >= ref_start) && ((cyc - ref_start) % ref_per == 0);
    c_fb   = fb_on && (cyc >= fb_start) && ((cyc - fb_start) % fb_per == 0);
    c_load = load_req;
    c_ch   = load_ch;
    load_req  = 0;
    ref_tick  = c_ref;
    fb_tick   = c_fb;
    chan_load = c_load;
    chan_sel  = CB'(c_ch);
  endtask

  task automatic compare();
    bit e_ref, e_fb;
    e_ref = c_ref && (m_rc == REF_DIV - 1);
    e_fb  = c_fb && (m_pc == PRE_DIV - 1) && (m_nc == m_ratio - 1);
    chk("R1 ref_pulse", ref_pulse, e_ref);
    chk("R2 fb_pulse", fb_pulse, e_fb);
    chk("R6 pump_up", pump_up, m_up);
    chk("R6 pump_dn", pump_dn, m_dn);
    chk("R7 locked", locked, m_run == LRUNS);
    chk("R4 range_err", range_err, m_err);
    if (fb_pulse) begin
      gaps.push_back(cyc - last_fb);
      last_fb = cyc;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    drive();
    @(negedge clk);
    compare();
    cyc++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load(int ch);
    load_req = 1;
    load_ch  = ch;
    step();
  endtask

  task automatic wait_fb();
    for (int i = 0; i < 400; i++) begin
      step();
      if (fb_pulse) break;
    end
  endtask

  task automatic chk_gap(string tag, int idx, int exp);
    if (gaps.size() <= idx) chk(tag, -1, exp);
    else chk(tag, gaps[idx], exp);
  endtask

  initial begin
    int first_fb;
    rst_n = 0; ref_tick = 0; fb_tick = 0; chan_load = 0; chan_sel = '0;
    m_rc = 0; m_pc = 0; m_nc = 0; m_ratio = clampr(RBASE); m_pend = m_ratio;
    m_pv = 0; m_up = 0; m_dn = 0; m_err = 0; m_slip = 0; m_run = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R5 reset pump_up", pump_up, 0);
    chk("R5 reset pump_dn", pump_dn, 0);
    chk("R5 reset locked", locked, 0);
    chk("R5 reset range_err", range_err, 0);
    rst_n = 1;
    run(4);

    // Acquire lock on channel 1 (ratio 4); first feedback cycle uses boot ratio 3.
    load(1);
    ref_on = 1; ref_per = 4; ref_start = cyc;
    fb_on = 1;  fb_per = 3;  fb_start = cyc + 4;
    first_fb = -1;
    for (int i = 0; i < 700; i++) begin
      step();
      if (fb_pulse && first_fb < 0) first_fb = cyc - 1 - fb_start;
    end
    chk("R5 boot ratio first feedback event", first_fb, 15);
    chk("R7 lock acquired", locked, 1);

    // Channel change: old cycle completes, then ratio 7.
    wait_fb();
    gaps.delete();
    load(2);
    step();
    chk("R7 load clears lock", locked, 0);
    chk("R4 in-range load", range_err, 0);
    run(150);
    chk_gap("R3 old ratio completes", 0, 24);
    chk_gap("R3 new ratio 7", 1, 42);

    // Two loads before the terminal count: the later wins.
    wait_fb();
    gaps.delete();
    load(4);
    load(5);
    run(250);
    chk_gap("R8 pending cycle", 0, 42);
    chk_gap("R8 later load ratio 16", 1, 96);

    // Above the upper bound: clamp to 20 and flag.
    wait_fb();
    gaps.delete();
    load(7);
    step();
    chk("R4 high clamp flag", range_err, 1);
    run(300);
    chk_gap("R3 pending cycle before clamp", 0, 96);
    chk_gap("R3 clamped to max", 1, 120);

    // Below the lower bound: clamp to 3 and flag.
    wait_fb();
    gaps.delete();
    load(0);
    step();
    chk("R4 low clamp flag", range_err, 1);
    run(200);
    chk_gap("R3 clamped to min", 1, 18);

    load(3);
    step();
    chk("R4 flag cleared by in-range load", range_err, 0);
    run(50);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule